// File: doc/BRIEF.md
# Serial Audio Bit and Word Clock Generator

This block turns an oversampled audio master clock into the two framing clocks that a serial audio converter needs: a bit clock and a word-select (left/right channel) clock. All of its logic runs on the master clock itself. Four configuration pins choose the behaviour:
- whether the master clock is 256 or 384 times the sample rate;
- whether each channel slot carries 16 or 32 bits;
- which word-select level marks the left channel;
- whether the block is enabled at all.

A data-available flag from the upstream converter gates the framing clocks. When the flag drops, the block finishes the frame in progress and then parks its outputs at a fixed idle level. When the flag returns, a new frame starts at a left slot.

Besides the clocks, the block drives two single-cycle strobes that a serializer uses to time its shifts. One marks the first cycle of every bit period. The other marks the first bit of every channel slot. It also drives an output-enable for the master-clock pad, which follows the enable pin. There is no data stream through the block: every pin is a plain level or strobe, so no valid/ready back-pressure applies.

Top module: `aclk_gen`

## Requirements
- R1: While reset is asserted and on the first sampling after it, `bclk_o`, `wsel_o`, `bit_strobe_o`, `slot_start_o` and `mclk_oe_o` are all 0. The sampled configuration resets to 256x, 16-bit slots and left-low.
- R2: While running, one bit-clock period lasts D master cycles: D=8 for 256x/16-bit, 4 for 256x/32-bit, 12 for 384x/16-bit and 6 for 384x/32-bit. `bclk_o` is 0 for the first D/2 cycles of each period and 1 for the remaining D/2.
- R3: One frame is two slots of S bit periods each, with S=16 when `slot_long_i`=0 and S=32 when it is 1. `slot_start_o` pulses on the first cycle of the first bit of every slot, and only together with `bit_strobe_o`.
- R4: `wsel_o` marks the left slot with the level of `left_high_i` (0: left while low, 1: left while high) and the right slot with the opposite level. While running, it changes only in a cycle where `bit_strobe_o` is 1, which is where the bit clock falls.
- R5: From idle, with `en_i`=1, `data_avail_i`=1 and no configuration change sampled on a clock edge, generation begins on the next cycle. That cycle is the first bit of a left slot, with `bit_strobe_o` and `slot_start_o` both at 1.
- R6: `bit_strobe_o` is 1 for exactly one master cycle at the start of each bit period, and `bclk_o` is 0 in that cycle.
- R7: If `data_avail_i` is 0 when the last master cycle of a frame is sampled, the block goes idle on the next cycle. Idle means `bclk_o`=0, both strobes 0, and `wsel_o` at the left level. If the flag is 1 at that point, the next frame follows with no gap, even if the flag was low earlier in the frame.
- R8: `mclk_oe_o` equals the value of `en_i` sampled on the previous clock edge.
- R9: If `en_i` is sampled 0, the block is idle on the next cycle with all counters cleared.
- R10: If any of `ratio_hi_i`, `slot_long_i` or `left_high_i` differs from the value sampled on the previous edge while `en_i` is 1, the block is idle on the next cycle. It then restarts as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampled master clock; all logic runs on it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Audio enable |
| ratio_hi_i | input | 1 | Master-clock ratio: 0 = 256x, 1 = 384x sample rate |
| slot_long_i | input | 1 | Slot size: 0 = 16 bits, 1 = 32 bits per channel |
| left_high_i | input | 1 | Word-select level of the left channel |
| data_avail_i | input | 1 | Converter input has audio data |
| mclk_oe_o | output | 1 | Output-enable for the master-clock pad |
| bclk_o | output | 1 | Serial bit clock |
| wsel_o | output | 1 | Word-select (left/right) clock |
| bit_strobe_o | output | 1 | One-cycle pulse at the start of each bit period |
| slot_start_o | output | 1 | One-cycle pulse at the first bit of each slot |

## Verification
Every output is a decode of registered state, so each result appears in the master cycle that follows the clock edge on which its cause was sampled:
- `mclk_oe_o` follows `en_i` one cycle later.
- A start, a stop, or a disable or configuration-triggered reset takes effect one cycle after it is sampled.
- The end-of-frame stop takes effect one cycle after the last frame cycle.

The bench drives inputs on the falling edge. On each rising edge it advances a behavioural model by one step from the inputs it has just sampled, and 2 ns later it compares all five outputs with that model. Every check therefore lands exactly on the cycle the requirements name.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  // Sampled configuration word.
  typedef struct packed {
    logic ratio_hi;   // 0: 256x, 1: 384x master clock
    logic slot_long;  // 0: 16-bit slots, 1: 32-bit slots
    logic left_high;  // word-select level of the left channel
  } aclk_cfg_t;

  localparam int unsigned NUM_MODES = 4;

  // Bit-clock divide ratio for one ratio/slot combination.
  function automatic int unsigned bit_div(input int unsigned base_lo,
                                          input int unsigned base_hi,
                                          input int unsigned slot_s,
                                          input int unsigned slot_l,
                                          input int unsigned mode);
    int unsigned base;
    int unsigned slot;
    base = (mode / 2 != 0) ? base_hi : base_lo;
    slot = (mode % 2 != 0) ? slot_l : slot_s;
    return base / (2 * slot);
  endfunction

endpackage

// File: rtl/aclk_cfg_track.sv
module aclk_cfg_track
  import aclk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  aclk_cfg_t cfg_i,
  output aclk_cfg_t cfg_q_o,
  output logic      cfg_chg_o,
  output logic      mclk_oe_o
);

  aclk_cfg_t cfg_q;
  logic      oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      cfg_q <= cfg_i;
      oe_q  <= en_i;
    end
  end

  assign cfg_q_o   = cfg_q;
  assign cfg_chg_o = en_i && (cfg_i != cfg_q);
  assign mclk_oe_o = oe_q;

endmodule

// File: rtl/aclk_bit_div.sv
module aclk_bit_div
  import aclk_pkg::*;
#(
  parameter int unsigned BASE_LO = 256,
  parameter int unsigned BASE_HI = 384,
  parameter int unsigned SLOT_S  = 16,
  parameter int unsigned SLOT_L  = 32,
  parameter int unsigned CNT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ratio_hi_i,
  input  logic             slot_long_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bit_end_o,
  output logic             high_phase_o
);

  logic [CNT_W-1:0] last_tab [NUM_MODES];
  logic [CNT_W-1:0] half_tab [NUM_MODES];

  for (genvar k = 0; k < NUM_MODES; k++) begin : g_mode
    localparam int unsigned DIV = bit_div(BASE_LO, BASE_HI, SLOT_S, SLOT_L, k);
    assign last_tab[k] = CNT_W'(DIV - 1);
    assign half_tab[k] = CNT_W'(DIV / 2);
  end

  logic [1:0]       mode;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             at_last;

  assign mode    = {ratio_hi_i, slot_long_i};
  assign last    = last_tab[mode];
  assign at_last = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || at_last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o        = cnt_q;
  assign bit_end_o    = at_last && !clr_i;
  assign high_phase_o = (cnt_q >= half_tab[mode]);

endmodule

// File: rtl/aclk_slot_ctr.sv
module aclk_slot_ctr #(
  parameter int unsigned SLOT_S = 16,
  parameter int unsigned SLOT_L = 32,
  parameter int unsigned BIT_W  = $clog2(SLOT_L)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             bit_end_i,
  input  logic             slot_long_i,
  output logic [BIT_W-1:0] bit_idx_o,
  output logic             right_o,
  output logic             frame_end_o
);

  localparam logic [BIT_W-1:0] LAST_S = BIT_W'(SLOT_S - 1);
  localparam logic [BIT_W-1:0] LAST_L = BIT_W'(SLOT_L - 1);

  logic [BIT_W-1:0] bit_q;
  logic             right_q;
  logic             slot_end;

  assign slot_end = bit_end_i && (bit_q == (slot_long_i ? LAST_L : LAST_S));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= '0;
      right_q <= 1'b0;
    end else if (clr_i) begin
      bit_q   <= '0;
      right_q <= 1'b0;
    end else if (slot_end) begin
      bit_q   <= '0;
      right_q <= !right_q;
    end else if (bit_end_i) begin
      bit_q   <= bit_q + 1'b1;
    end
  end

  assign bit_idx_o   = bit_q;
  assign right_o     = right_q;
  assign frame_end_o = slot_end && right_q;

endmodule

// File: rtl/aclk_run_ctl.sv
module aclk_run_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cfg_chg_i,
  input  logic data_avail_i,
  input  logic frame_end_i,
  output logic run_o,
  output logic clr_o
);

  logic run_q;
  logic run_d;

  always_comb begin
    if (!en_i || cfg_chg_i) begin
      run_d = 1'b0;
    end else if (!run_q) begin
      run_d = data_avail_i;
    end else if (frame_end_i && !data_avail_i) begin
      run_d = 1'b0;
    end else begin
      run_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  assign run_o = run_q;
  // Counters are held at zero whenever the generator is idle or is forced idle.
  assign clr_o = !run_q || !en_i || cfg_chg_i;

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int unsigned BASE_LO = 256,
  parameter int unsigned BASE_HI = 384,
  parameter int unsigned SLOT_S  = 16,
  parameter int unsigned SLOT_L  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ratio_hi_i,
  input  logic slot_long_i,
  input  logic left_high_i,
  input  logic data_avail_i,
  output logic mclk_oe_o,
  output logic bclk_o,
  output logic wsel_o,
  output logic bit_strobe_o,
  output logic slot_start_o
);

  localparam int unsigned MAX_DIV = BASE_HI / (2 * SLOT_S);
  localparam int unsigned CNT_W   = $clog2(MAX_DIV);
  localparam int unsigned BIT_W   = $clog2(SLOT_L);

  aclk_cfg_t        cfg_in;
  aclk_cfg_t        cfg_q;
  logic             cfg_chg;
  logic             run_q;
  logic             clr;
  logic [CNT_W-1:0] cnt;
  logic             bit_end;
  logic             high_phase;
  logic [BIT_W-1:0] bit_idx;
  logic             right;
  logic             frame_end;

  assign cfg_in = '{ratio_hi: ratio_hi_i, slot_long: slot_long_i, left_high: left_high_i};

  aclk_cfg_track u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .cfg_i     (cfg_in),
    .cfg_q_o   (cfg_q),
    .cfg_chg_o (cfg_chg),
    .mclk_oe_o (mclk_oe_o)
  );

  aclk_run_ctl u_run (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .cfg_chg_i    (cfg_chg),
    .data_avail_i (data_avail_i),
    .frame_end_i  (frame_end),
    .run_o        (run_q),
    .clr_o        (clr)
  );

  aclk_bit_div #(
    .BASE_LO (BASE_LO),
    .BASE_HI (BASE_HI),
    .SLOT_S  (SLOT_S),
    .SLOT_L  (SLOT_L),
    .CNT_W   (CNT_W)
  ) u_div (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .ratio_hi_i   (cfg_q.ratio_hi),
    .slot_long_i  (cfg_q.slot_long),
    .cnt_o        (cnt),
    .bit_end_o    (bit_end),
    .high_phase_o (high_phase)
  );

  aclk_slot_ctr #(
    .SLOT_S (SLOT_S),
    .SLOT_L (SLOT_L),
    .BIT_W  (BIT_W)
  ) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .bit_end_i   (bit_end),
    .slot_long_i (cfg_q.slot_long),
    .bit_idx_o   (bit_idx),
    .right_o     (right),
    .frame_end_o (frame_end)
  );

  // Output decode: idle holds bclk low and word select at the left level.
  assign bclk_o       = run_q && high_phase;
  assign bit_strobe_o = run_q && (cnt == '0);
  assign slot_start_o = bit_strobe_o && (bit_idx == '0);
  assign wsel_o       = run_q ? (right ^ cfg_q.left_high) : cfg_q.left_high;

endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic ratio_hi_i,
  input logic slot_long_i,
  input logic left_high_i,
  input logic mclk_oe_o,
  input logic bclk_o,
  input logic wsel_o,
  input logic bit_strobe_o,
  input logic slot_start_o,
  input logic run_q
);

  assert_strobe_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_strobe_o |-> !bclk_o);

  assert_slot_in_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_o |-> bit_strobe_o);

  assert_wsel_on_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && !$stable(wsel_o)) |-> bit_strobe_o);

  assert_mclk_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> mclk_oe_o);

  assert_mclk_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mclk_oe_o);

  assert_disable_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!bclk_o && !bit_strobe_o && !slot_start_o && (wsel_o == $past(left_high_i))));

  assert_cfg_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && en_i &&
     (!$stable(ratio_hi_i) || !$stable(slot_long_i) || !$stable(left_high_i)))
    |=> (!bclk_o && !bit_strobe_o));

  assert_start_left_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (slot_start_o && (wsel_o == $past(left_high_i))));

endmodule

bind aclk_gen aclk_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .ratio_hi_i   (ratio_hi_i),
  .slot_long_i  (slot_long_i),
  .left_high_i  (left_high_i),
  .mclk_oe_o    (mclk_oe_o),
  .bclk_o       (bclk_o),
  .wsel_o       (wsel_o),
  .bit_strobe_o (bit_strobe_o),
  .slot_start_o (slot_start_o),
  .run_q        (run_q)
);

// File: tb/sim_aclk_gen.sv
`timescale 1ns/1ps
module sim_aclk_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ratio_hi = 1'b0, slot_long = 1'b0, left_high = 1'b0, avail = 1'b0;
  logic mclk_oe, bclk, wsel, bstb, sstb;

  int checks = 0;
  int fails  = 0;
  string scen = "R1";

  always #4 clk = ~clk;  // 125 MHz

  aclk_gen u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .ratio_hi_i   (ratio_hi),
    .slot_long_i  (slot_long),
    .left_high_i  (left_high),
    .data_avail_i (avail),
    .mclk_oe_o    (mclk_oe),
    .bclk_o       (bclk),
    .wsel_o       (wsel),
    .bit_strobe_o (bstb),
    .slot_start_o (sstb)
  );

  // Behavioural reference state.
  int m_run = 0, m_cnt = 0, m_bit = 0, m_right = 0;
  int q_ratio = 0, q_slot = 0, q_pol = 0, m_oe = 0;

  function automatic int div_of(int r, int s);
    return (r != 0 ? 384 : 256) / (s != 0 ? 64 : 32);
  endfunction

  task automatic chk(string tag, logic act, int exp);
    checks++;
    if (act !== exp[0]) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual=%0b expected=%0d", tag, scen, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int d, s;
    bit chg;
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_bit = 0; m_right = 0;
      q_ratio = 0; q_slot = 0; q_pol = 0; m_oe = 0;
    end else begin
      d = div_of(q_ratio, q_slot);
      s = (q_slot != 0) ? 32 : 16;
      chg = (ratio_hi != q_ratio[0]) || (slot_long != q_slot[0]) || (left_high != q_pol[0]);
      if (!en || chg) begin
        m_run = 0; m_cnt = 0; m_bit = 0; m_right = 0;
      end else if (m_run == 0) begin
        m_run = avail ? 1 : 0;
      end else if (m_cnt == d - 1) begin
        m_cnt = 0;
        if (m_bit == s - 1) begin
          m_bit = 0;
          if (m_right != 0 && !avail) m_run = 0;
          m_right = 1 - m_right;
        end else begin
          m_bit++;
        end
      end else begin
        m_cnt++;
      end
      q_ratio = ratio_hi; q_slot = slot_long; q_pol = left_high; m_oe = en;
    end
    #2;
    begin
      int dd;
      dd = div_of(q_ratio, q_slot);
      chk("R2 bclk", bclk, (m_run != 0 && m_cnt >= dd / 2) ? 1 : 0);
      chk("R4 wsel", wsel, (m_run != 0) ? (m_right ^ q_pol) : q_pol);
      chk("R6 bit_strobe", bstb, (m_run != 0 && m_cnt == 0) ? 1 : 0);
      chk("R3 slot_start", sstb, (m_run != 0 && m_cnt == 0 && m_bit == 0) ? 1 : 0);
      chk("R8 mclk_oe", mclk_oe, m_oe);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Directed period check for R2: cycles between two bit strobes.
  task automatic period_chk(int exp);
    int n;
    @(posedge bstb);
    n = 0;
    @(negedge clk);
    while (bstb) @(negedge clk);
    n = 1;
    while (!bstb) begin @(negedge clk); n++; end
    checks++;
    if (n != exp) begin
      fails++;
      $display("FAIL R2 period actual=%0d expected=%0d", n, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    scen = "R1 reset";
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    scen = "R8 enable";
    en = 1'b1;
    cyc(4);
    scen = "R5 start 256x16";
    avail = 1'b1;
    cyc(2);
    period_chk(8);
    cyc(560);
    scen = "R10 polarity change";
    left_high = 1'b1;
    cyc(600);
    scen = "R10 slot 32";
    slot_long = 1'b1;
    cyc(3);
    period_chk(4);
    cyc(400);
    scen = "R10 ratio 384 slot 32";
    ratio_hi = 1'b1;
    cyc(3);
    period_chk(6);
    cyc(800);
    scen = "R10 ratio 384 slot 16";
    slot_long = 1'b0;
    left_high = 1'b0;
    cyc(3);
    period_chk(12);
    cyc(900);
    scen = "R7 data drop";
    avail = 1'b0;
    cyc(1000);
    scen = "R5 data return";
    avail = 1'b1;
    cyc(500);
    scen = "R7 short glitch";
    avail = 1'b0;
    cyc(20);
    avail = 1'b1;
    cyc(900);
    scen = "R9 disable";
    en = 1'b0;
    cyc(30);
    en = 1'b1;
    cyc(300);
    scen = "R7 drop 256x32";
    ratio_hi = 1'b0;
    slot_long = 1'b1;
    cyc(100);
    avail = 1'b0;
    cyc(400);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule